// File: doc/BRIEF.md
# Twelve-Bit Accumulator Data Path

This block is the central 12-bit data path of a small accumulator machine. A source selector places one of seven registers or buses on the A input of an arithmetic/logic unit. The B input is always the accumulator. A one-hot operation request picks what the unit computes, and the answer appears on a 12-bit result bus in the same cycle, together with a carry out of the top bit.

The result bus is the only path into the five working registers: memory address, memory buffer, program counter, instruction and accumulator. Each register captures the bus on a rising clock edge when its own load enable is high. One selector position carries a shared minibus. The effective address, formed from the instruction and memory buffer registers, drives it during the address-fetch step. External input data drives it during an input transfer.

The control sequencer that raises the operation requests and load enables sits outside this block. So do memory timing and the I/O handshake.

Top module: `dp12_datapath`

## Requirements
- R1: A synchronous active-high reset clears all five registers to zero on the next rising edge.
- R2: Select code 0 routes the accumulator to A, 1 the memory address register, 2 the memory buffer, 3 the memory data input, 4 the program counter, 5 the switch register input, and 6 the minibus. Code 7 is spare and supplies zero.
- R3: The minibus carries the effective address while the address-drive input is high. Otherwise it carries the external input while the input-enable is high. With neither input high it carries zero, and the effective address wins if both are high.
- R4: The effective address takes its low 7 bits from instruction bits [6:0]. Its upper 5 bits are memory buffer bits [11:7] when instruction bit 7 (the current-page flag) is set, and zero when that bit is clear.
- R5: The result bus follows the inputs combinationally. Increment gives A+1, plus gives A+AC, and gives A&AC, or gives A|AC, not gives ~A, zero gives 0, and pass gives A, all modulo 2^12.
- R6: The request bits are increment 0, plus 1, and 2, or 3, not 4, zero 5, and pass 6. With no bit set the unit passes A. With several bits set, the lowest-numbered bit wins.
- R7: The carry output is the carry out of bit 11 for increment and plus, and is 0 for every other operation.
- R8: Load-enable bits are memory address 0, memory buffer 1, program counter 2, instruction 3, and accumulator 4. A register captures the result bus on a rising edge only when its bit is set, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 3 | A-input source code |
| op_req | input | 7 | One-hot operation request |
| ld_en | input | 5 | Per-register load enables |
| mem_data | input | 12 | Memory read data |
| sw_reg | input | 12 | Switch register value |
| ext_in | input | 12 | External input data |
| ext_in_en | input | 1 | External input drives the minibus |
| ea_drive | input | 1 | Effective address drives the minibus |
| alu_out | output | 12 | Result bus |
| carry_out | output | 1 | Carry out of bit 11 |
| ac_q | output | 12 | Accumulator |
| ma_q | output | 12 | Memory address register |
| mb_q | output | 12 | Memory buffer register |
| pc_q | output | 12 | Program counter |
| ir_q | output | 12 | Instruction register |

## Verification
The hardest case to reach is the effective address. It depends on two internal registers, and the only way to fill them is through the result bus itself. The stimulus therefore first builds known values in the memory buffer and instruction registers using chains of operations and loads. It then selects the minibus with the current-page flag both set and cleared. The same register history also proves that registers whose enables stayed low did not move, because later results depend on their held values.

// File: rtl/dp12_pkg.sv
package dp12_pkg;

    parameter int unsigned DP_W    = 12;
    parameter int unsigned OFFS_W  = 7;
    parameter int unsigned N_OPS   = 7;
    parameter int unsigned N_REGS  = 5;

    typedef enum logic [2:0] {
        SRC_AC    = 3'd0,
        SRC_MA    = 3'd1,
        SRC_MB    = 3'd2,
        SRC_MEM   = 3'd3,
        SRC_PC    = 3'd4,
        SRC_SW    = 3'd5,
        SRC_MINI  = 3'd6,
        SRC_SPARE = 3'd7
    } src_sel_e;

    typedef enum logic [2:0] {
        ALU_INC  = 3'd0,
        ALU_PLUS = 3'd1,
        ALU_AND  = 3'd2,
        ALU_OR   = 3'd3,
        ALU_NOT  = 3'd4,
        ALU_ZERO = 3'd5,
        ALU_PASS = 3'd6
    } alu_op_e;

    localparam int unsigned REG_MA = 0;
    localparam int unsigned REG_MB = 1;
    localparam int unsigned REG_PC = 2;
    localparam int unsigned REG_IR = 3;
    localparam int unsigned REG_AC = 4;

    // lowest set request bit wins; nothing set means pass
    function automatic alu_op_e pick_op(input logic [N_OPS-1:0] req);
        alu_op_e sel;
        logic    found;
        sel   = ALU_PASS;
        found = 1'b0;
        for (int i = 0; i < int'(N_OPS); i++) begin
            if (req[i] && !found) begin
                sel   = alu_op_e'(i[2:0]);
                found = 1'b1;
            end
        end
        return sel;
    endfunction

endpackage

// File: rtl/dp12_ea_gen.sv
module dp12_ea_gen #(
    parameter int unsigned W      = 12,
    parameter int unsigned OFFS_W = 7
) (
    input  logic [W-1:0] ir,
    input  logic [W-1:0] mb,
    input  logic         ea_drive,
    input  logic         ext_in_en,
    input  logic [W-1:0] ext_in,
    output logic [W-1:0] minibus
);
    localparam int unsigned PAGE_W = W - OFFS_W;

    logic            cur_page;
    logic [W-1:0]    ea;

    assign cur_page = ir[OFFS_W];

    always_comb begin
        ea[OFFS_W-1:0] = ir[OFFS_W-1:0];
        ea[W-1:OFFS_W] = cur_page ? mb[W-1:OFFS_W] : {PAGE_W{1'b0}};
    end

    always_comb begin
        if (ea_drive)
            minibus = ea;
        else if (ext_in_en)
            minibus = ext_in;
        else
            minibus = '0;
    end
endmodule

// File: rtl/dp12_src_mux.sv
module dp12_src_mux
    import dp12_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic [2:0]   src_sel,
    input  logic [W-1:0] ac,
    input  logic [W-1:0] ma,
    input  logic [W-1:0] mb,
    input  logic [W-1:0] mem,
    input  logic [W-1:0] pc,
    input  logic [W-1:0] sw,
    input  logic [W-1:0] minibus,
    output logic [W-1:0] a_bus
);
    src_sel_e sel;
    assign sel = src_sel_e'(src_sel);

    always_comb begin
        unique case (sel)
            SRC_AC:   a_bus = ac;
            SRC_MA:   a_bus = ma;
            SRC_MB:   a_bus = mb;
            SRC_MEM:  a_bus = mem;
            SRC_PC:   a_bus = pc;
            SRC_SW:   a_bus = sw;
            SRC_MINI: a_bus = minibus;
            default:  a_bus = '0;
        endcase
    end
endmodule

// File: rtl/dp12_alu.sv
module dp12_alu
    import dp12_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic [N_OPS-1:0] op_req,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     y,
    output logic             cout
);
    alu_op_e     op;
    logic [W:0]  wide;

    assign op = pick_op(op_req);

    always_comb begin
        wide = '0;
        unique case (op)
            ALU_INC:  wide = {1'b0, a} + {{W{1'b0}}, 1'b1};
            ALU_PLUS: wide = {1'b0, a} + {1'b0, b};
            ALU_AND:  wide = {1'b0, a & b};
            ALU_OR:   wide = {1'b0, a | b};
            ALU_NOT:  wide = {1'b0, ~a};
            ALU_ZERO: wide = '0;
            default:  wide = {1'b0, a};
        endcase
    end

    assign y    = wide[W-1:0];
    assign cout = wide[W];
endmodule

// File: rtl/dp12_regs.sv
module dp12_regs #(
    parameter int unsigned W = 12,
    parameter int unsigned N = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        ld_en,
    input  logic [W-1:0]        d,
    output logic [N-1:0][W-1:0] q
);
    for (genvar g = 0; g < int'(N); g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[g] <= '0;
            else if (ld_en[g])
                q[g] <= d;
        end
    end
endmodule

// File: rtl/dp12_datapath.sv
module dp12_datapath
    import dp12_pkg::*;
#(
    parameter int unsigned W      = DP_W,
    parameter int unsigned OFFS_W = dp12_pkg::OFFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        src_sel,
    input  logic [N_OPS-1:0]  op_req,
    input  logic [N_REGS-1:0] ld_en,
    input  logic [W-1:0]      mem_data,
    input  logic [W-1:0]      sw_reg,
    input  logic [W-1:0]      ext_in,
    input  logic              ext_in_en,
    input  logic              ea_drive,
    output logic [W-1:0]      alu_out,
    output logic              carry_out,
    output logic [W-1:0]      ac_q,
    output logic [W-1:0]      ma_q,
    output logic [W-1:0]      mb_q,
    output logic [W-1:0]      pc_q,
    output logic [W-1:0]      ir_q
);
    logic [N_REGS-1:0][W-1:0] regs;
    logic [W-1:0]             minibus;
    logic [W-1:0]             a_bus;

    assign ac_q = regs[REG_AC];
    assign ma_q = regs[REG_MA];
    assign mb_q = regs[REG_MB];
    assign pc_q = regs[REG_PC];
    assign ir_q = regs[REG_IR];

    dp12_ea_gen #(.W(W), .OFFS_W(OFFS_W)) u_ea (
        .ir        (ir_q),
        .mb        (mb_q),
        .ea_drive  (ea_drive),
        .ext_in_en (ext_in_en),
        .ext_in    (ext_in),
        .minibus   (minibus)
    );

    dp12_src_mux #(.W(W)) u_mux (
        .src_sel (src_sel),
        .ac      (ac_q),
        .ma      (ma_q),
        .mb      (mb_q),
        .mem     (mem_data),
        .pc      (pc_q),
        .sw      (sw_reg),
        .minibus (minibus),
        .a_bus   (a_bus)
    );

    dp12_alu #(.W(W)) u_alu (
        .op_req (op_req),
        .a      (a_bus),
        .b      (ac_q),
        .y      (alu_out),
        .cout   (carry_out)
    );

    dp12_regs #(.W(W), .N(N_REGS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .ld_en (ld_en),
        .d     (alu_out),
        .q     (regs)
    );
endmodule

// File: rtl/dp12_datapath_chk.sv
module dp12_datapath_chk
    import dp12_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        src_sel,
    input logic [N_OPS-1:0]  op_req,
    input logic [N_REGS-1:0] ld_en,
    input logic              ext_in_en,
    input logic              ea_drive,
    input logic [W-1:0]      alu_out,
    input logic              carry_out,
    input logic [W-1:0]      ac_q,
    input logic [W-1:0]      ma_q,
    input logic [W-1:0]      mb_q,
    input logic [W-1:0]      pc_q,
    input logic [W-1:0]      ir_q
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (ac_q == '0 && ma_q == '0 && mb_q == '0 && pc_q == '0 && ir_q == '0));

    p_spare_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 3'd7 && op_req == 7'h40) |-> alu_out == '0);

    p_idle_minibus_r3: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 3'd6 && !ea_drive && !ext_in_en && op_req == 7'h40) |-> alu_out == '0);

    p_zero_op_r5: assert property (@(posedge clk) disable iff (rst)
        (op_req == 7'h20) |-> alu_out == '0);

    p_no_carry_r7: assert property (@(posedge clk) disable iff (rst)
        (op_req[1:0] == 2'b00) |-> !carry_out);

    p_ac_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !ld_en[REG_AC] |=> $stable(ac_q));

    p_ac_load_r8: assert property (@(posedge clk) disable iff (rst)
        ld_en[REG_AC] |=> ac_q == $past(alu_out));

    p_ir_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !ld_en[REG_IR] |=> $stable(ir_q));

    p_ma_load_r8: assert property (@(posedge clk) disable iff (rst)
        ld_en[REG_MA] |=> ma_q == $past(alu_out));
endmodule

bind dp12_datapath dp12_datapath_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_sel   (src_sel),
    .op_req    (op_req),
    .ld_en     (ld_en),
    .ext_in_en (ext_in_en),
    .ea_drive  (ea_drive),
    .alu_out   (alu_out),
    .carry_out (carry_out),
    .ac_q      (ac_q),
    .ma_q      (ma_q),
    .mb_q      (mb_q),
    .pc_q      (pc_q),
    .ir_q      (ir_q)
);

// File: tb/dp12_datapath_test.sv
`timescale 1ns/1ps
module dp12_datapath_test;

    typedef struct packed {
        logic [2:0]  sel;
        logic [6:0]  op;
        logic [4:0]  ld;
        logic [11:0] sw;
        logic [11:0] mem;
        logic [11:0] exp_y;
        logic        exp_c;
    } vec_t;

    // ops: INC 01 PLUS 02 AND 04 OR 08 NOT 10 ZERO 20 PASS 40
    // loads: MA 01 MB 02 PC 04 IR 08 AC 10
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{3'd5, 7'h40, 5'h10, 12'h0F0, 12'h000, 12'h0F0, 1'b0},
        '{3'd3, 7'h02, 5'h00, 12'h000, 12'h010, 12'h100, 1'b0},
        '{3'd3, 7'h02, 5'h10, 12'h000, 12'hF20, 12'h010, 1'b1},
        '{3'd5, 7'h04, 5'h00, 12'h7EF, 12'h000, 12'h000, 1'b0},
        '{3'd5, 7'h08, 5'h02, 12'hA05, 12'h000, 12'hA15, 1'b0},
        '{3'd2, 7'h10, 5'h01, 12'h000, 12'h000, 12'h5EA, 1'b0},
        '{3'd1, 7'h01, 5'h04, 12'h000, 12'h000, 12'h5EB, 1'b0},
        '{3'd5, 7'h01, 5'h00, 12'hFFF, 12'h000, 12'h000, 1'b1},
        '{3'd4, 7'h20, 5'h10, 12'h000, 12'h000, 12'h000, 1'b0},
        '{3'd1, 7'h00, 5'h08, 12'h000, 12'h000, 12'h5EA, 1'b0},
        '{3'd7, 7'h40, 5'h00, 12'h000, 12'h000, 12'h000, 1'b0},
        '{3'd4, 7'h02, 5'h00, 12'h000, 12'h000, 12'h5EB, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  src_sel = '0;
    logic [6:0]  op_req = '0;
    logic [4:0]  ld_en = '0;
    logic [11:0] mem_data = '0, sw_reg = '0, ext_in = '0;
    logic        ext_in_en = 1'b0, ea_drive = 1'b0;
    logic [11:0] alu_out, ac_q, ma_q, mb_q, pc_q, ir_q;
    logic        carry_out;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dp12_datapath uut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .op_req(op_req), .ld_en(ld_en),
        .mem_data(mem_data), .sw_reg(sw_reg), .ext_in(ext_in),
        .ext_in_en(ext_in_en), .ea_drive(ea_drive),
        .alu_out(alu_out), .carry_out(carry_out),
        .ac_q(ac_q), .ma_q(ma_q), .mb_q(mb_q), .pc_q(pc_q), .ir_q(ir_q)
    );

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at the falling edge, look at the result bus, then let the rising edge load
    task automatic step(input logic [2:0] s, input logic [6:0] o, input logic [4:0] l,
                        input logic [11:0] sw, input logic [11:0] mem,
                        input logic [11:0] ey, input logic ec, input string tag);
        @(negedge clk);
        src_sel = s; op_req = o; ld_en = l; sw_reg = sw; mem_data = mem;
        #2;
        check(tag, alu_out, ey);
        check({tag, " carry R7"}, {11'd0, carry_out}, {11'd0, ec});
        @(posedge clk);
        #1;
        ld_en = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: registers cleared by reset
        check("R1 ac", ac_q, 12'h000);
        check("R1 ma", ma_q, 12'h000);
        check("R1 mb", mb_q, 12'h000);
        check("R1 pc", pc_q, 12'h000);
        check("R1 ir", ir_q, 12'h000);
        @(negedge clk);
        rst = 1'b0;

        // R2 R5 R6 R7 R8: table walk
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].sel, VECS[i].op, VECS[i].ld, VECS[i].sw, VECS[i].mem,
                 VECS[i].exp_y, VECS[i].exp_c, $sformatf("R5 vector %0d", i));
        end

        // R8: each register holds what its own enable captured
        check("R8 ac", ac_q, 12'h000);
        check("R8 ma", ma_q, 12'h5EA);
        check("R8 mb", mb_q, 12'hA15);
        check("R8 pc", pc_q, 12'h5EB);
        check("R8 ir", ir_q, 12'h5EA);

        // R4: current-page flag set (ir=5EA, mb=A15) -> A6A
        ea_drive = 1'b1;
        step(3'd6, 7'h40, 5'h00, 12'h000, 12'h000, 12'hA6A, 1'b0, "R4 page set");
        // R3: address wins over external input
        ext_in = 12'h3C3; ext_in_en = 1'b1;
        step(3'd6, 7'h40, 5'h00, 12'h000, 12'h000, 12'hA6A, 1'b0, "R3 priority");
        ea_drive = 1'b0;
        step(3'd6, 7'h40, 5'h00, 12'h000, 12'h000, 12'h3C3, 1'b0, "R3 ext input");
        ext_in_en = 1'b0;
        step(3'd6, 7'h40, 5'h00, 12'h000, 12'h000, 12'h000, 1'b0, "R3 idle bus");
        // R4: clear the page flag via IR=055
        step(3'd5, 7'h40, 5'h08, 12'h055, 12'h000, 12'h055, 1'b0, "R8 ir load");
        ea_drive = 1'b1;
        step(3'd6, 7'h40, 5'h00, 12'h000, 12'h000, 12'h055, 1'b0, "R4 page clear");
        ea_drive = 1'b0;

        // R2: accumulator on A
        step(3'd5, 7'h40, 5'h10, 12'h321, 12'h000, 12'h321, 1'b0, "R2 ac load");
        step(3'd0, 7'h40, 5'h00, 12'h000, 12'h000, 12'h321, 1'b0, "R2 ac source");
        step(3'd0, 7'h02, 5'h00, 12'h000, 12'h000, 12'h642, 1'b0, "R5 ac plus ac");
        // R6: increment and zero both requested -> increment
        step(3'd5, 7'h21, 5'h00, 12'h123, 12'h000, 12'h124, 1'b0, "R6 priority");
        // R6: or beats not
        step(3'd5, 7'h18, 5'h00, 12'h00C, 12'h000, 12'h32D, 1'b0, "R6 or over not");

        // R1: reset again after loads
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 ac again", ac_q, 12'h000);
        check("R1 ir again", ir_q, 12'h000);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule